// File: doc/BRIEF.md
# Segmented memory map translator

This unit turns a 32-bit tagged address and a byte count into a physical address, a memory-space code and a byte count that has been clipped to a boundary. It can also report a fault instead. The top byte of the address is a tag. Three tag values name physical unified, instruction and data memory, and these addresses pass through unchanged. Two further tag values name a logical data window and a logical instruction window. Addresses in those windows are translated through a small bank of 16-bit map registers.

Software programs the map registers through a simple write port that sits in the top page of the data address space. The same address reads the value back combinationally. The logical data window is split into equal blocks, one per data map register. The last data map register is special: it always points into I/O space. Its block is cut into four sub-windows, and each sub-window takes its 4-bit page number from one nibble of that register. The instruction window has a test mode that folds the offset onto a small mirror at the bottom of instruction memory.

The translation itself is combinational. The result is captured on each request and appears one clock later together with a valid pulse.

Top module: `mmt_translator`

## Requirements
- R1: Bits 31:24 of `req_addr` form the tag. Tags 0x00, 0x01, 0x02, 0x10 and 0x11 are accepted. Any other tag, and every fault listed below, gives `rsp_fault`=1 with `rsp_len`=0, `rsp_phys`=0 and `rsp_space`=3 (none).
- R2: Tags 0x00, 0x01 and 0x02 return `rsp_phys` equal to `req_addr` and `rsp_space` equal to the tag (0 unified, 1 instruction, 2 data). The count is cut so that the access ends at the next 64 KiB segment boundary.
- R3: Under tag 0x10, an offset (bits 23:0) of 4 × 16 KiB or more faults. Under tag 0x11, an offset of 2 × 128 KiB or more faults.
- R4: In the logical data window, the block index is offset / 16 KiB and the in-block offset is offset mod 16 KiB. The count is cut at the end of the block, so the returned count never exceeds the requested one.
- R5: For data map registers 0 to 2, bits 13:12 select the target and bits 9:0 give the segment. Code 0 yields unified memory at segment × 16 KiB + in-block offset. Code 1 yields instruction memory (base 0x01000000) using the same sum.
- R6: Data map code 2 yields data memory at 0x02000000 + segment × 0x10000 + index × 16 KiB + in-block offset. Data map code 3 faults.
- R7: Data map register 3 always targets data space. The sub-window is s = (in-block offset / 0x1000) mod 4. The page is nibble (3 − s) of the register, so s=0 uses bits 15:12. The address is 0x02000000 + page × 0x10000 + 0xC000 + in-block offset.
- R8: For instruction map registers, bits 13:12 select the target and bits 6:0 give the segment. Code 0 yields unified memory at segment × 0x20000 + in-block offset. Code 1 yields instruction memory at 0x01000000 + index × 128 KiB + in-block offset. Code 2 faults. The count is cut at the end of the 128 KiB block.
- R9: Instruction map code 3 is a test mirror. It yields 0x01000000 + (in-block offset mod 0x800), and the count is also cut at the next 0x800 boundary.
- R10: A write with `cfg_we` to 0xFF00 + 2k loads instruction map k (k = 0, 1). A write to 0xFF08 + 2k loads data map k (k = 0 to 3). `cfg_rdata` returns the register at `cfg_addr`. Writes to any other address change nothing, and reads there return 0.
- R11: Address 0xFF04 is a shadow of 0xFF0C. Writes and reads there act on data map 2.
- R12: Reset clears every map register and `rsp_valid`. `rsp_valid` is high exactly one cycle after a cycle with `req_valid`, and the response fields hold that request's result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Map register write strobe |
| cfg_addr | input | 16 | Map register byte address |
| cfg_wdata | input | 16 | Map register write data |
| cfg_rdata | output | 16 | Map register read data (combinational) |
| req_valid | input | 1 | Translation request |
| req_addr | input | 32 | Tagged address |
| req_len | input | 18 | Requested byte count |
| rsp_valid | output | 1 | Result valid, one cycle after request |
| rsp_fault | output | 1 | Translation fault |
| rsp_space | output | 2 | 0 unified, 1 instruction, 2 data, 3 none |
| rsp_phys | output | 32 | Physical address including space tag |
| rsp_len | output | 18 | Clipped byte count |

## Verification
The hardest situations to reach from the ports need a particular map-register value and a particular address at the same time. Examples are an I/O sub-window whose page nibble differs from its neighbours, a test-mirror access that runs past the 0x800 edge, and a data-memory segment combined with a non-zero block index. The bench therefore rewrites the whole map bank with random values every few requests. It draws offsets concentrated near the window limits and lengths concentrated near block ends. It then adds directed cases that set each nibble of the I/O register to a different page, and it uses the shadow address to program data map 2 before translating through it.

// File: rtl/mmt_pkg.sv
package mmt_pkg;

  typedef enum logic [1:0] {
    SP_UNIF = 2'd0,
    SP_INSN = 2'd1,
    SP_DATA = 2'd2,
    SP_NONE = 2'd3
  } mmt_space_e;

  typedef struct packed {
    logic        fault;
    mmt_space_e  space;
    logic [31:0] phys;
    logic [31:0] len;
  } mmt_xlat_t;

  localparam logic [7:0]  TAG_PUNIF = 8'h00;
  localparam logic [7:0]  TAG_PINSN = 8'h01;
  localparam logic [7:0]  TAG_PDATA = 8'h02;
  localparam logic [7:0]  TAG_LDATA = 8'h10;
  localparam logic [7:0]  TAG_LINSN = 8'h11;

  localparam logic [15:0] IMAP_ADDR   = 16'hFF00;
  localparam logic [15:0] DMAP_ADDR   = 16'hFF08;
  localparam logic [15:0] SHADOW_ADDR = 16'hFF04;
  localparam logic [15:0] SHADOW_TGT  = 16'hFF0C;

  localparam logic [31:0] IO_HOLE  = 32'h0000_C000;
  localparam logic [31:0] TEST_WIN = 32'h0000_0800;

  // Cut a count so that inblk + count does not pass size.
  function automatic logic [31:0] clip_len(input logic [31:0] inblk,
                                           input logic [31:0] n,
                                           input logic [31:0] size);
    logic [32:0] end_pos;
    end_pos = {1'b0, inblk} + {1'b0, n};
    return (end_pos > {1'b0, size}) ? (size - inblk) : n;
  endfunction

  function automatic logic [31:0] space_base(input mmt_space_e sp);
    return {6'd0, sp, 24'd0};
  endfunction

  function automatic mmt_xlat_t fault_result();
    mmt_xlat_t r;
    r.fault = 1'b1;
    r.space = SP_NONE;
    r.phys  = '0;
    r.len   = '0;
    return r;
  endfunction

  function automatic mmt_xlat_t ok_result(input mmt_space_e sp,
                                          input logic [31:0] phys,
                                          input logic [31:0] len);
    mmt_xlat_t r;
    r.fault = 1'b0;
    r.space = sp;
    r.phys  = phys;
    r.len   = len;
    return r;
  endfunction

endpackage

// File: rtl/mmt_regbank.sv
module mmt_regbank
  import mmt_pkg::*;
#(
  parameter int NIMAP = 2,
  parameter int NDMAP = 4
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cfg_we,
  input  logic [15:0]            cfg_addr,
  input  logic [15:0]            cfg_wdata,
  output logic [15:0]            cfg_rdata,
  output logic [NIMAP-1:0][15:0] imap,
  output logic [NDMAP-1:0][15:0] dmap
);

  logic [15:0]      eff_addr;
  logic [NIMAP-1:0] imap_sel;
  logic [NDMAP-1:0] dmap_sel;
  logic             any_sel;

  assign eff_addr = (cfg_addr == SHADOW_ADDR) ? SHADOW_TGT : cfg_addr;
  assign any_sel  = |{imap_sel, dmap_sel};

  for (genvar k = 0; k < NIMAP; k++) begin : g_imap
    assign imap_sel[k] = (eff_addr == IMAP_ADDR + 16'(2 * k));
    always_ff @(posedge clk) begin
      if (!rst_n)                    imap[k] <= '0;
      else if (cfg_we && imap_sel[k]) imap[k] <= cfg_wdata;
    end
  end

  for (genvar k = 0; k < NDMAP; k++) begin : g_dmap
    assign dmap_sel[k] = (eff_addr == DMAP_ADDR + 16'(2 * k));
    always_ff @(posedge clk) begin
      if (!rst_n)                    dmap[k] <= '0;
      else if (cfg_we && dmap_sel[k]) dmap[k] <= cfg_wdata;
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int k = 0; k < NIMAP; k++)
      if (imap_sel[k]) cfg_rdata = cfg_rdata | imap[k];
    for (int k = 0; k < NDMAP; k++)
      if (dmap_sel[k]) cfg_rdata = cfg_rdata | dmap[k];
  end

  // R10: a write that hits no register leaves the whole bank unchanged
  assert_ignored_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && !any_sel) |=> ($stable(imap) && $stable(dmap)));

  if (NDMAP > 2) begin : g_shadow_chk
    // R11: writing the shadow address lands in data map 2
    assert_shadow_alias_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_we && cfg_addr == SHADOW_ADDR) |=> (dmap[2] == $past(cfg_wdata)));
  end

endmodule

// File: rtl/mmt_dmap_xlate.sv
module mmt_dmap_xlate
  import mmt_pkg::*;
#(
  parameter int NDMAP   = 4,
  parameter int DBLK_LG = 14
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [31:0]            off,
  input  logic [31:0]            len,
  input  logic [NDMAP-1:0][15:0] dmap,
  output mmt_xlat_t              res
);

  localparam int          IDX_W = (NDMAP > 1) ? $clog2(NDMAP) : 1;
  localparam logic [31:0] DBLK  = 32'(1) << DBLK_LG;
  localparam logic [31:0] DWIN  = DBLK * 32'(NDMAP);

  logic              in_win;
  logic [IDX_W-1:0]  idx;
  logic [31:0]       inblk;
  logic [31:0]       n_clip;
  logic [15:0]       map;
  logic              io_hit;
  logic [1:0]        sub;
  logic [3:0]        page;
  logic [1:0]        code;
  logic [31:0]       seg;

  assign in_win = (off < DWIN);
  assign idx    = IDX_W'(off >> DBLK_LG);
  assign inblk  = off & (DBLK - 32'd1);
  assign n_clip = clip_len(inblk, len, DBLK);
  assign map    = dmap[idx];
  assign io_hit = in_win && (32'(idx) == 32'(NDMAP - 1));
  assign sub    = inblk[13:12];
  assign page   = 4'(map >> (4 * (3 - int'(sub))));
  assign code   = map[13:12];
  assign seg    = {22'd0, map[9:0]};

  always_comb begin
    if (!in_win)
      res = fault_result();
    else if (io_hit)
      res = ok_result(SP_DATA,
                      space_base(SP_DATA) + ({28'd0, page} << 16) + IO_HOLE + inblk,
                      n_clip);
    else begin
      unique case (code)
        2'd0: res = ok_result(SP_UNIF, (seg << DBLK_LG) + inblk, n_clip);
        2'd1: res = ok_result(SP_INSN, space_base(SP_INSN) + (seg << DBLK_LG) + inblk, n_clip);
        2'd2: res = ok_result(SP_DATA, space_base(SP_DATA) + (seg << 16)
                              + (32'(idx) << DBLK_LG) + inblk, n_clip);
        default: res = fault_result();
      endcase
    end
  end

  // R7: the I/O register always lands in the data-space I/O hole
  assert_io_hole_R7: assert property (@(posedge clk) disable iff (!rst_n)
    io_hit |-> (!res.fault && res.space == SP_DATA && res.phys[15:14] == 2'b11));

  // R6: reserved code faults outside the I/O register
  assert_reserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && !io_hit && code == 2'd3) |-> (res.fault && res.len == 32'd0));

endmodule

// File: rtl/mmt_imap_xlate.sv
module mmt_imap_xlate
  import mmt_pkg::*;
#(
  parameter int NIMAP   = 2,
  parameter int IBLK_LG = 17
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [31:0]            off,
  input  logic [31:0]            len,
  input  logic [NIMAP-1:0][15:0] imap,
  output mmt_xlat_t              res
);

  localparam int          IDX_W = (NIMAP > 1) ? $clog2(NIMAP) : 1;
  localparam logic [31:0] IBLK  = 32'(1) << IBLK_LG;
  localparam logic [31:0] IWIN  = IBLK * 32'(NIMAP);

  logic             in_win;
  logic [IDX_W-1:0] idx;
  logic [31:0]      inblk;
  logic [31:0]      n_clip;
  logic [15:0]      map;
  logic [1:0]       code;
  logic [31:0]      seg;
  logic [31:0]      t_off;
  logic [31:0]      t_len;
  logic             test_hit;
  logic             unused_map;

  assign in_win   = (off < IWIN);
  assign idx      = IDX_W'(off >> IBLK_LG);
  assign inblk    = off & (IBLK - 32'd1);
  assign n_clip   = clip_len(inblk, len, IBLK);
  assign map      = imap[idx];
  assign code     = map[13:12];
  assign seg      = {25'd0, map[6:0]};
  assign t_off    = inblk & (TEST_WIN - 32'd1);
  assign t_len    = clip_len(t_off, n_clip, TEST_WIN);
  assign test_hit = in_win && (code == 2'd3);
  assign unused_map = ^{map[15:14], map[11:7]};

  always_comb begin
    if (!in_win)
      res = fault_result();
    else begin
      unique case (code)
        2'd0: res = ok_result(SP_UNIF, (seg << 17) + inblk, n_clip);
        2'd1: res = ok_result(SP_INSN, space_base(SP_INSN) + (32'(idx) << IBLK_LG) + inblk, n_clip);
        2'd2: res = fault_result();
        default: res = ok_result(SP_INSN, space_base(SP_INSN) + t_off, t_len);
      endcase
    end
  end

  // R9: test mirror stays in the bottom 0x800 bytes and never runs past it
  assert_test_mirror_R9: assert property (@(posedge clk) disable iff (!rst_n)
    test_hit |-> (res.phys[31:11] == 21'h2000 && ({21'd0, res.phys[10:0]} + res.len) <= TEST_WIN));

  // R8: reserved code faults
  assert_imap_reserved_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_win && code == 2'd2) |-> res.fault);

endmodule

// File: rtl/mmt_translator.sv
module mmt_translator
  import mmt_pkg::*;
#(
  parameter int NIMAP   = 2,
  parameter int NDMAP   = 4,
  parameter int DBLK_LG = 14,
  parameter int IBLK_LG = 17,
  parameter int SEG_LG  = 16,
  parameter int LEN_W   = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [15:0]      cfg_addr,
  input  logic [15:0]      cfg_wdata,
  output logic [15:0]      cfg_rdata,
  input  logic             req_valid,
  input  logic [31:0]      req_addr,
  input  logic [LEN_W-1:0] req_len,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [1:0]       rsp_space,
  output logic [31:0]      rsp_phys,
  output logic [LEN_W-1:0] rsp_len
);

  localparam logic [31:0] SEG = 32'(1) << SEG_LG;

  logic [NIMAP-1:0][15:0] imap;
  logic [NDMAP-1:0][15:0] dmap;
  logic [7:0]             tag;
  logic [31:0]            off;
  logic [31:0]            len32;
  logic                   tag_known;
  mmt_xlat_t              d_res, i_res, p_res, sel_res;

  assign tag       = req_addr[31:24];
  assign off       = {8'd0, req_addr[23:0]};
  assign len32     = 32'(req_len);
  assign tag_known = (tag == TAG_PUNIF) || (tag == TAG_PINSN) || (tag == TAG_PDATA)
                  || (tag == TAG_LDATA) || (tag == TAG_LINSN);

  mmt_regbank #(.NIMAP(NIMAP), .NDMAP(NDMAP)) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .imap(imap), .dmap(dmap)
  );

  mmt_dmap_xlate #(.NDMAP(NDMAP), .DBLK_LG(DBLK_LG)) u_dxl (
    .clk(clk), .rst_n(rst_n), .off(off), .len(len32), .dmap(dmap), .res(d_res)
  );

  mmt_imap_xlate #(.NIMAP(NIMAP), .IBLK_LG(IBLK_LG)) u_ixl (
    .clk(clk), .rst_n(rst_n), .off(off), .len(len32), .imap(imap), .res(i_res)
  );

  // Physical pass-through: address kept, count cut at segment end.
  assign p_res = ok_result(mmt_space_e'(tag[1:0]), req_addr,
                           clip_len(off & (SEG - 32'd1), len32, SEG));

  always_comb begin
    unique case (tag)
      TAG_PUNIF, TAG_PINSN, TAG_PDATA: sel_res = p_res;
      TAG_LDATA:                       sel_res = d_res;
      TAG_LINSN:                       sel_res = i_res;
      default:                         sel_res = fault_result();
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_fault <= 1'b0;
      rsp_space <= SP_NONE;
      rsp_phys  <= '0;
      rsp_len   <= '0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_fault <= sel_res.fault;
        rsp_space <= sel_res.space;
        rsp_phys  <= sel_res.phys;
        rsp_len   <= LEN_W'(sel_res.len);
      end
    end
  end

  // R12: one response per request, one cycle later
  assert_rsp_timing_R12: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  assert_rsp_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R1: an unknown tag gives a fault response
  assert_unknown_tag_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !tag_known) |=> (rsp_fault && rsp_space == SP_NONE));

  // R1: every fault carries a zero count
  assert_fault_len_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_len == '0 && rsp_phys == '0));

  // R4: the count can only shrink
  assert_len_shrinks_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> (rsp_len <= $past(req_len)));

endmodule

// File: tb/test_mmt_translator.sv
module test_mmt_translator;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [15:0] cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [15:0] cfg_rdata;
  logic        req_valid = 1'b0;
  logic [31:0] req_addr = '0;
  logic [17:0] req_len = '0;
  logic        rsp_valid, rsp_fault;
  logic [1:0]  rsp_space;
  logic [31:0] rsp_phys;
  logic [17:0] rsp_len;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  logic [15:0] bm_i [2];
  logic [15:0] bm_d [4];

  always #5 clk = ~clk;

  mmt_translator i_mmt_translator (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .req_valid(req_valid),
    .req_addr(req_addr), .req_len(req_len), .rsp_valid(rsp_valid),
    .rsp_fault(rsp_fault), .rsp_space(rsp_space), .rsp_phys(rsp_phys),
    .rsp_len(rsp_len)
  );

  // Reference model written from the requirements with plain arithmetic.
  function automatic void model(input logic [31:0] a, input longint n,
                                output logic [31:0] ph, output logic [1:0] sp,
                                output longint ln, output bit flt);
    longint off, ib, idx, r, seg, s, pg, t;
    logic [15:0] m;
    int code;
    flt = 0; ph = 0; sp = 3; ln = 0;
    off = longint'(a & 32'h00FF_FFFF);
    case (a[31:24])
      8'h00, 8'h01, 8'h02: begin
        sp = a[25:24]; ph = a;
        r  = off % 65536;
        ln = (r + n > 65536) ? 65536 - r : n;
      end
      8'h10: begin
        if (off >= 4 * 16384) flt = 1;
        else begin
          idx = off / 16384; ib = off % 16384;
          ln  = (ib + n > 16384) ? 16384 - ib : n;
          m   = bm_d[idx];
          if (idx == 3) begin
            s  = (ib / 4096) % 4;
            pg = (longint'(m) >> (4 * (3 - s))) % 16;
            ph = 32'(64'h0200_0000 + pg * 65536 + 64'hC000 + ib); sp = 2;
          end else begin
            code = int'(m[13:12]); seg = longint'(m) % 1024;
            case (code)
              0: begin ph = 32'(seg * 16384 + ib); sp = 0; end
              1: begin ph = 32'(64'h0100_0000 + seg * 16384 + ib); sp = 1; end
              2: begin ph = 32'(64'h0200_0000 + seg * 65536 + idx * 16384 + ib); sp = 2; end
              default: flt = 1;
            endcase
          end
        end
      end
      8'h11: begin
        if (off >= 2 * 131072) flt = 1;
        else begin
          idx = off / 131072; ib = off % 131072;
          ln  = (ib + n > 131072) ? 131072 - ib : n;
          m   = bm_i[idx];
          code = int'(m[13:12]); seg = longint'(m) % 128;
          case (code)
            0: begin ph = 32'(seg * 131072 + ib); sp = 0; end
            1: begin ph = 32'(64'h0100_0000 + idx * 131072 + ib); sp = 1; end
            2: flt = 1;
            default: begin
              t  = ib % 2048;
              ph = 32'(64'h0100_0000 + t); sp = 1;
              if (t + ln > 2048) ln = 2048 - t;
            end
          endcase
        end
      end
      default: flt = 1;
    endcase
    if (flt) begin ph = 0; sp = 3; ln = 0; end
  endfunction

  task automatic check(input bit ok, input string req, input string msg);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: %s", req, msg);
    end
  endtask

  task automatic cfg_write(input logic [15:0] ad, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = ad; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
    // bench mirror of the register map (R10, R11)
    if (ad == 16'hFF04) bm_d[2] = d;
    else if (ad == 16'hFF00 || ad == 16'hFF02) bm_i[(ad - 16'hFF00) / 2] = d;
    else if (ad >= 16'hFF08 && ad <= 16'hFF0E && !ad[0]) bm_d[(ad - 16'hFF08) / 2] = d;
  endtask

  task automatic cfg_read(input logic [15:0] ad, input logic [15:0] exp, input string req);
    @(negedge clk);
    cfg_addr = ad;
    #1;
    check(cfg_rdata === exp, req,
          $sformatf("read %h actual=%h expected=%h", ad, cfg_rdata, exp));
  endtask

  task automatic xlate(input logic [31:0] a, input logic [17:0] n, input string req);
    logic [31:0] eph; logic [1:0] esp; longint eln; bit eflt;
    model(a, longint'(n), eph, esp, eln, eflt);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_len = n;
    @(negedge clk);
    req_valid = 1'b0;
    check(rsp_valid === 1'b1 && rsp_fault === eflt && rsp_space === esp &&
          rsp_phys === eph && rsp_len === 18'(eln), req,
          $sformatf("addr=%h len=%0d actual v=%b f=%b sp=%0d ph=%h ln=%0d expected f=%b sp=%0d ph=%h ln=%0d",
                    a, n, rsp_valid, rsp_fault, rsp_space, rsp_phys, rsp_len,
                    eflt, esp, eph, eln));
  endtask

  function automatic logic [31:0] rand_addr();
    logic [31:0] a;
    int pick;
    pick = int'($urandom_range(0, 9));
    a = $urandom;
    case (pick)
      0: a[31:24] = 8'h00;
      1: a[31:24] = 8'h01;
      2: a[31:24] = 8'h02;
      3, 4, 5: begin a[31:24] = 8'h10; a[23:0] = 24'($urandom_range(0, 32'h11000)); end
      6, 7, 8: begin a[31:24] = 8'h11; a[23:0] = 24'($urandom_range(0, 32'h44000)); end
      default: ;
    endcase
    return a;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: run did not finish");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    foreach (bm_i[k]) bm_i[k] = '0;
    foreach (bm_d[k]) bm_d[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R12: reset state
    check(rsp_valid === 1'b0, "R12", $sformatf("rsp_valid after reset actual=%b expected=0", rsp_valid));
    cfg_read(16'hFF00, 16'h0000, "R12");
    cfg_read(16'hFF0E, 16'h0000, "R12");

    // R10: register port writes and reads, ignored addresses
    cfg_write(16'hFF00, 16'h1003);
    cfg_write(16'hFF02, 16'h3000);
    cfg_write(16'hFF08, 16'h0005);
    cfg_write(16'hFF0A, 16'h1002);
    cfg_write(16'hFF0E, 16'h1234);
    cfg_read(16'hFF00, 16'h1003, "R10");
    cfg_read(16'hFF0E, 16'h1234, "R10");
    cfg_write(16'hFF10, 16'hBEEF);
    cfg_write(16'hFF09, 16'hBEEF);
    cfg_read(16'hFF10, 16'h0000, "R10");
    cfg_read(16'hFF08, 16'h0005, "R10");
    cfg_read(16'hFF0A, 16'h1002, "R10");

    // R11: shadow address programs data map 2
    cfg_write(16'hFF04, 16'h2011);
    cfg_read(16'hFF0C, 16'h2011, "R11");
    cfg_read(16'hFF04, 16'h2011, "R11");
    xlate(32'h1000_8123, 18'd16, "R11");

    // R12: no request gives no valid
    @(negedge clk);
    check(rsp_valid === 1'b0, "R12", $sformatf("idle rsp_valid actual=%b expected=0", rsp_valid));

    // R1: unknown tags
    xlate(32'h0300_0010, 18'd4, "R1");
    xlate(32'hFF00_0000, 18'd4, "R1");
    xlate(32'h1200_0000, 18'd4, "R1");
    // R2: physical pass-through and segment clip
    xlate(32'h0212_FFF0, 18'd32, "R2");
    xlate(32'h0100_0000, 18'd100, "R2");
    xlate(32'h0004_8000, 18'h20000, "R2");
    // R3: window limits
    xlate(32'h1000_FFFF, 18'd1, "R3");
    xlate(32'h1001_0000, 18'd1, "R3");
    xlate(32'h1103_FFFF, 18'd1, "R3");
    xlate(32'h1104_0000, 18'd1, "R3");
    // R4: block-end clip in the data window
    xlate(32'h1000_3FFE, 18'd8, "R4");
    // R5: data code 0 and 1
    xlate(32'h1000_0100, 18'd2, "R5");
    xlate(32'h1000_7F00, 18'h400, "R5");
    // R6: data code 2 and 3
    cfg_write(16'hFF08, 16'h2155);
    xlate(32'h1000_0040, 18'd2, "R6");
    cfg_write(16'hFF0A, 16'h3001);
    xlate(32'h1000_4000, 18'd2, "R6");
    // R7: each I/O sub-window takes its own nibble
    cfg_write(16'hFF0E, 16'h9A5C);
    xlate(32'h1000_C000, 18'd2, "R7");
    xlate(32'h1000_D004, 18'd2, "R7");
    xlate(32'h1000_E800, 18'd2, "R7");
    xlate(32'h1000_FFFC, 18'd16, "R7");
    // R8: instruction codes 0, 1, 2
    cfg_write(16'hFF00, 16'h007F);
    xlate(32'h1101_2340, 18'd8, "R8");
    cfg_write(16'hFF02, 16'h1000);
    xlate(32'h1103_FFF0, 18'h100, "R8");
    cfg_write(16'hFF02, 16'h2000);
    xlate(32'h1102_0000, 18'd4, "R8");
    // R9: test mirror with clip at 0x800
    cfg_write(16'hFF00, 16'h3000);
    xlate(32'h1101_27F8, 18'd64, "R9");
    xlate(32'h1100_0010, 18'd16, "R9");

    // Random mix
    for (int it = 0; it < 600; it++) begin
      if (it % 8 == 0) begin
        for (int k = 0; k < 2; k++) cfg_write(16'hFF00 + 16'(2 * k), 16'($urandom));
        for (int k = 0; k < 4; k++)
          cfg_write((k == 2 && it % 16 == 0) ? 16'hFF04 : 16'hFF08 + 16'(2 * k), 16'($urandom));
      end
      xlate(rand_addr(),
            ($urandom_range(0, 3) == 0) ? 18'($urandom) : 18'($urandom_range(0, 2100)),
            "R1 R2 R3 R4 R5 R6 R7 R8 R9");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule